// File: doc/BRIEF.md
# Programmable Address Window Decoder

This block maps a CPU-side 32-bit access address onto a downstream target. It holds eight windows. Each window has a control word with an enable bit, a 4-bit target ID, an 8-bit attribute and a 16-bit size mask counted in 64 KB units, plus a base address. The lowest windows also carry a low and a high remap word that translate the address into a 64-bit downstream address. The other windows pass the address through unchanged.

Decoding is purely combinational from the live register contents. For every address the block reports a hit together with the winning window, its target, its attribute and the translated address, or it raises a miss. A plain synchronous write port and a combinational read port program the windows. Register writes take effect at the clock edge that accepts them. Software is therefore expected to disable a window before it rewrites that window's base.

Top module: `addrwin_decoder`

## Requirements
- R1: Register byte offset = window*0x10 + slot*4, with slot 0 = control, 1 = base, 2 = remap low, 3 = remap high; offset bits 1:0 are ignored. Control layout: enable bit 0, target bits 7:4, attribute bits 15:8, size bits 31:16; control bits 3:1 read back as zero and every other written control bit reads back unchanged.
- R2: After reset every register of every window reads zero, every window is disabled, and every address misses.
- R3: An enabled window matches when (addr[31:16] & ~size) == (base[31:16] & ~size); with a contiguous-ones size field the window spans (size+1) x 64 KB, so size 0x0000 covers 64 KB and 0x00FF covers 16 MB.
- R4: A window whose enable bit is 0 never matches, whatever its base and size.
- R5: When several enabled windows match, the lowest-numbered one wins (win, target and attribute come from it).
- R6: Windows 0 and 1 translate: output bits 31:16 = (remap_low[31:16] & ~size) | (addr[31:16] & size), bits 15:0 = addr[15:0], bits 63:32 = remap_high; remap low equal to the base leaves the address unchanged.
- R7: Windows 2 to 7 output {32'h0, addr}; their remap slots read zero and writes to them are ignored.
- R8: The base and remap-low registers keep only bits 31:16; bits 15:0 read back as zero and never affect decoding.
- R9: On a miss, dec_hit = 0, dec_miss = 1 and dec_win, dec_target, dec_attr and dec_addr are all zero.
- R10: Decoding uses the current register values: a write accepted at a clock edge changes the decode result from that edge on, with no further delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register byte offset (write and read) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| acc_addr | input | 32 | Access address to decode |
| dec_hit | output | 1 | Some enabled window matches |
| dec_miss | output | 1 | No enabled window matches |
| dec_win | output | 3 | Index of the winning window |
| dec_target | output | 4 | Target ID of the winning window |
| dec_attr | output | 8 | Attribute of the winning window |
| dec_addr | output | 64 | Translated downstream address |

## Verification
The assertions assume reg_we, reg_addr and reg_wdata are driven to known values at every sampled edge and that reg_we stays low during reset. Under that assumption, the read-back property can pair a write with a read of the same offset one edge later. The properties do not assume that size fields are contiguous or that base rewrites happen only while a window is disabled. The directed stimulus still programs only contiguous size masks. It always clears the enable bit before changing a base, so the window spans that the bench predicts are well defined.

// File: rtl/addrwin_pkg.sv
package addrwin_pkg;
   localparam int DATA_W   = 32;
   localparam int XADDR_W  = 64;
   localparam int SIZE_W   = 16;
   localparam int TGT_W    = 4;
   localparam int ATTR_W   = 8;
   localparam int PAGE_W   = DATA_W - SIZE_W;   // offset bits inside a 64 KB page
   localparam int EN_BIT   = 0;
   localparam int TGT_LSB  = 4;
   localparam int ATTR_LSB = 8;
   localparam int SIZE_LSB = 16;

   typedef enum logic [1:0] {
      SLOT_CTRL = 2'd0,
      SLOT_BASE = 2'd1,
      SLOT_RLO  = 2'd2,
      SLOT_RHI  = 2'd3
   } slot_e;

   typedef struct packed {
      logic                en;
      logic [TGT_W-1:0]    tgt;
      logic [ATTR_W-1:0]   attr;
      logic [SIZE_W-1:0]   size;
      logic [SIZE_W-1:0]   base_hi;
      logic [SIZE_W-1:0]   rlo_hi;
      logic [DATA_W-1:0]   rhi;
   } win_cfg_t;
endpackage

// File: rtl/addrwin_regs.sv
module addrwin_regs
   import addrwin_pkg::*;
#(
   parameter int NUM_WIN    = 8,
   parameter int REMAP_WINS = 2,
   parameter int WIN_W      = 3,
   parameter int RA_W       = WIN_W + 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      we,
   input  logic [RA_W-1:0]           addr,
   input  logic [DATA_W-1:0]         wdata,
   output logic [DATA_W-1:0]         rdata,
   output win_cfg_t [NUM_WIN-1:0]    cfg
);
   logic [WIN_W-1:0] sel_win;
   slot_e            sel_slot;
   logic             unused_addr_lsb;

   assign sel_win         = addr[RA_W-1:4];
   assign sel_slot        = slot_e'(addr[3:2]);
   assign unused_addr_lsb = &{1'b0, addr[1:0]};

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      logic              wsel;
      logic              en_q;
      logic [TGT_W-1:0]  tgt_q;
      logic [ATTR_W-1:0] attr_q;
      logic [SIZE_W-1:0] size_q;
      logic [SIZE_W-1:0] base_q;
      logic [SIZE_W-1:0] rlo_v;
      logic [DATA_W-1:0] rhi_v;

      assign wsel = we && (sel_win == WIN_W'(w));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            en_q   <= 1'b0;
            tgt_q  <= '0;
            attr_q <= '0;
            size_q <= '0;
            base_q <= '0;
         end else if (wsel && sel_slot == SLOT_CTRL) begin
            en_q   <= wdata[EN_BIT];
            tgt_q  <= wdata[TGT_LSB +: TGT_W];
            attr_q <= wdata[ATTR_LSB +: ATTR_W];
            size_q <= wdata[SIZE_LSB +: SIZE_W];
         end else if (wsel && sel_slot == SLOT_BASE) begin
            base_q <= wdata[DATA_W-1 -: SIZE_W];
         end
      end

      if (w < REMAP_WINS) begin : g_remap
         logic [SIZE_W-1:0] rlo_q;
         logic [DATA_W-1:0] rhi_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               rlo_q <= '0;
               rhi_q <= '0;
            end else if (wsel && sel_slot == SLOT_RLO) begin
               rlo_q <= wdata[DATA_W-1 -: SIZE_W];
            end else if (wsel && sel_slot == SLOT_RHI) begin
               rhi_q <= wdata;
            end
         end
         assign rlo_v = rlo_q;
         assign rhi_v = rhi_q;
      end else begin : g_plain
         assign rlo_v = '0;
         assign rhi_v = '0;
      end

      assign cfg[w] = '{en: en_q, tgt: tgt_q, attr: attr_q, size: size_q,
                        base_hi: base_q, rlo_hi: rlo_v, rhi: rhi_v};
   end

   always_comb begin
      win_cfg_t cur;
      cur   = '0;
      rdata = '0;
      if (int'(sel_win) < NUM_WIN) begin
         cur = cfg[sel_win];
         case (sel_slot)
            SLOT_CTRL: rdata = {cur.size, cur.attr, cur.tgt, 3'b000, cur.en};
            SLOT_BASE: rdata = {cur.base_hi, {PAGE_W{1'b0}}};
            SLOT_RLO:  rdata = {cur.rlo_hi, {PAGE_W{1'b0}}};
            default:   rdata = cur.rhi;
         endcase
      end
   end
endmodule

// File: rtl/addrwin_match.sv
module addrwin_match
   import addrwin_pkg::*;
#(
   parameter bit HAS_REMAP = 1'b0
) (
   input  win_cfg_t             cfg,
   input  logic [DATA_W-1:0]    addr,
   output logic                 hit,
   output logic [XADDR_W-1:0]   xaddr
);
   logic [SIZE_W-1:0] page;
   logic [SIZE_W-1:0] fixed_mask;

   assign page       = addr[DATA_W-1 -: SIZE_W];
   assign fixed_mask = ~cfg.size;
   assign hit        = cfg.en && ((page & fixed_mask) == (cfg.base_hi & fixed_mask));

   if (HAS_REMAP) begin : g_xlate
      assign xaddr = {cfg.rhi,
                      (cfg.rlo_hi & fixed_mask) | (page & cfg.size),
                      addr[PAGE_W-1:0]};
   end else begin : g_pass
      logic unused_remap;
      assign unused_remap = &{1'b0, cfg.rlo_hi, cfg.rhi};
      assign xaddr = {{(XADDR_W-DATA_W){1'b0}}, addr};
   end
endmodule

// File: rtl/addrwin_prio.sv
module addrwin_prio
   import addrwin_pkg::*;
#(
   parameter int NUM_WIN = 8,
   parameter int WIN_W   = 3
) (
   input  logic [NUM_WIN-1:0]                hits,
   input  logic [NUM_WIN-1:0][TGT_W-1:0]     tgts,
   input  logic [NUM_WIN-1:0][ATTR_W-1:0]    attrs,
   input  logic [NUM_WIN-1:0][XADDR_W-1:0]   xaddrs,
   output logic                              any_hit,
   output logic [WIN_W-1:0]                  win,
   output logic [TGT_W-1:0]                  tgt,
   output logic [ATTR_W-1:0]                 attr,
   output logic [XADDR_W-1:0]                xaddr
);
   assign any_hit = |hits;

   // scan from the top so the lowest matching index is written last
   always_comb begin
      win   = '0;
      tgt   = '0;
      attr  = '0;
      xaddr = '0;
      for (int w = NUM_WIN - 1; w >= 0; w--) begin
         if (hits[w]) begin
            win   = WIN_W'(w);
            tgt   = tgts[w];
            attr  = attrs[w];
            xaddr = xaddrs[w];
         end
      end
   end
endmodule

// File: rtl/addrwin_decoder.sv
module addrwin_decoder
   import addrwin_pkg::*;
#(
   parameter int NUM_WIN    = 8,
   parameter int REMAP_WINS = 2,
   parameter int WIN_W      = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
   parameter int RA_W       = WIN_W + 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_we,
   input  logic [RA_W-1:0]      reg_addr,
   input  logic [DATA_W-1:0]    reg_wdata,
   output logic [DATA_W-1:0]    reg_rdata,
   input  logic [DATA_W-1:0]    acc_addr,
   output logic                 dec_hit,
   output logic                 dec_miss,
   output logic [WIN_W-1:0]     dec_win,
   output logic [TGT_W-1:0]     dec_target,
   output logic [ATTR_W-1:0]    dec_attr,
   output logic [XADDR_W-1:0]   dec_addr
);
   if (NUM_WIN < 1 || (1 << WIN_W) < NUM_WIN) begin : g_bad_count
      $error("addrwin_decoder: NUM_WIN does not fit WIN_W");
   end
   if (REMAP_WINS < 0 || REMAP_WINS > NUM_WIN) begin : g_bad_remap
      $error("addrwin_decoder: REMAP_WINS out of range");
   end
   if (RA_W != WIN_W + 4) begin : g_bad_ra
      $error("addrwin_decoder: RA_W must be WIN_W + 4");
   end

   win_cfg_t [NUM_WIN-1:0]              cfg;
   logic [NUM_WIN-1:0]                  hits;
   logic [NUM_WIN-1:0][TGT_W-1:0]       tgts;
   logic [NUM_WIN-1:0][ATTR_W-1:0]      attrs;
   logic [NUM_WIN-1:0][XADDR_W-1:0]     xaddrs;

   addrwin_regs #(
      .NUM_WIN   (NUM_WIN),
      .REMAP_WINS(REMAP_WINS),
      .WIN_W     (WIN_W),
      .RA_W      (RA_W)
   ) u_regs (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (reg_we),
      .addr (reg_addr),
      .wdata(reg_wdata),
      .rdata(reg_rdata),
      .cfg  (cfg)
   );

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_match
      addrwin_match #(
         .HAS_REMAP(w < REMAP_WINS)
      ) u_match (
         .cfg  (cfg[w]),
         .addr (acc_addr),
         .hit  (hits[w]),
         .xaddr(xaddrs[w])
      );
      assign tgts[w]  = cfg[w].tgt;
      assign attrs[w] = cfg[w].attr;
   end

   addrwin_prio #(
      .NUM_WIN(NUM_WIN),
      .WIN_W  (WIN_W)
   ) u_prio (
      .hits   (hits),
      .tgts   (tgts),
      .attrs  (attrs),
      .xaddrs (xaddrs),
      .any_hit(dec_hit),
      .win    (dec_win),
      .tgt    (dec_target),
      .attr   (dec_attr),
      .xaddr  (dec_addr)
   );

   assign dec_miss = ~dec_hit;
endmodule

// File: rtl/addrwin_checker.sv
module addrwin_checker
   import addrwin_pkg::*;
#(
   parameter int NUM_WIN    = 8,
   parameter int REMAP_WINS = 2,
   parameter int WIN_W      = 3,
   parameter int RA_W       = WIN_W + 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 reg_we,
   input logic [RA_W-1:0]      reg_addr,
   input logic [DATA_W-1:0]    reg_wdata,
   input logic [DATA_W-1:0]    reg_rdata,
   input logic [DATA_W-1:0]    acc_addr,
   input logic                 dec_hit,
   input logic                 dec_miss,
   input logic [WIN_W-1:0]     dec_win,
   input logic [TGT_W-1:0]     dec_target,
   input logic [ATTR_W-1:0]    dec_attr,
   input logic [XADDR_W-1:0]   dec_addr
);
   localparam logic [DATA_W-1:0] CTRL_KEEP = 32'hFFFF_FFF1;

   // R1
   ctrl_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(reg_we) && reg_addr == $past(reg_addr) &&
       $past(reg_addr[3:2]) == 2'd0)
      |-> reg_rdata == ($past(reg_wdata) & CTRL_KEEP));

   // R2
   reset_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> dec_miss);

   // R6
   page_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec_hit |-> dec_addr[15:0] == acc_addr[15:0]);

   // R7
   plain_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_hit && int'(dec_win) >= REMAP_WINS)
      |-> dec_addr == {{(XADDR_W-DATA_W){1'b0}}, acc_addr});

   // R8
   base_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr[3:2] == 2'd1 || reg_addr[3:2] == 2'd2) |-> reg_rdata[15:0] == 16'h0);

   // R9
   miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec_miss |-> (dec_addr == '0 && dec_target == '0 && dec_attr == '0 && dec_win == '0));
endmodule

bind addrwin_decoder addrwin_checker #(
   .NUM_WIN   (NUM_WIN),
   .REMAP_WINS(REMAP_WINS),
   .WIN_W     (WIN_W),
   .RA_W      (RA_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_we    (reg_we),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .acc_addr  (acc_addr),
   .dec_hit   (dec_hit),
   .dec_miss  (dec_miss),
   .dec_win   (dec_win),
   .dec_target(dec_target),
   .dec_attr  (dec_attr),
   .dec_addr  (dec_addr)
);

// File: tb/addrwin_decoder_test.sv
`timescale 1ns/1ps
module addrwin_decoder_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [6:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [31:0] acc_addr = '0;
   logic        dec_hit, dec_miss;
   logic [2:0]  dec_win;
   logic [3:0]  dec_target;
   logic [7:0]  dec_attr;
   logic [63:0] dec_addr;

   int nchk = 0;
   int nerr = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   addrwin_decoder uut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_addr(acc_addr),
      .dec_hit(dec_hit), .dec_miss(dec_miss), .dec_win(dec_win),
      .dec_target(dec_target), .dec_attr(dec_attr), .dec_addr(dec_addr)
   );

   task automatic check(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] mk_ctrl(input bit en, input logic [3:0] t,
                                           input logic [7:0] a, input logic [15:0] s);
      return {s, a, t, 3'b000, en};
   endfunction

   task automatic wr(input int win, input int slot, input logic [31:0] d);
      @(negedge clk);
      reg_we    = 1'b1;
      reg_addr  = 7'(win * 16 + slot * 4);
      reg_wdata = d;
      @(negedge clk);
      reg_we    = 1'b0;
   endtask

   task automatic rd_chk(input string req, input int win, input int slot,
                         input logic [31:0] exp);
      @(negedge clk);
      reg_addr = 7'(win * 16 + slot * 4);
      #1;
      check(req, $sformatf("read w%0d s%0d", win, slot), 64'(reg_rdata), 64'(exp));
   endtask

   task automatic dec_chk(input string req, input logic [31:0] a, input bit hit,
                          input int win, input logic [3:0] t, input logic [7:0] at,
                          input logic [63:0] xa);
      @(negedge clk);
      acc_addr = a;
      #1;
      check(req, $sformatf("hit/miss @%h", a), {62'b0, dec_hit, dec_miss}, {62'b0, hit, ~hit});
      check(req, $sformatf("win/tgt/attr @%h", a), {49'b0, dec_win, dec_target, dec_attr},
            {49'b0, 3'(win), t, at});
      check(req, $sformatf("xaddr @%h", a), dec_addr, xa);
   endtask

   task automatic t_reset();
      rd_chk("R2", 0, 0, 32'h0);
      rd_chk("R2", 0, 2, 32'h0);
      rd_chk("R2", 1, 3, 32'h0);
      rd_chk("R2", 7, 0, 32'h0);
      rd_chk("R2", 7, 1, 32'h0);
      dec_chk("R2", 32'h0000_0000, 1'b0, 0, 4'h0, 8'h00, 64'h0);
      dec_chk("R2", 32'hFFFF_FFFF, 1'b0, 0, 4'h0, 8'h00, 64'h0);
   endtask

   task automatic t_regs();
      wr(0, 1, 32'h8000_1234);
      rd_chk("R8", 0, 1, 32'h8000_0000);
      wr(0, 2, 32'h4000_5678);
      rd_chk("R8", 0, 2, 32'h4000_0000);
      wr(0, 3, 32'h0000_0001);
      rd_chk("R1", 0, 3, 32'h0000_0001);
      wr(0, 0, 32'h0FFF_AB5F);
      rd_chk("R1", 0, 0, 32'h0FFF_AB51);
      wr(5, 2, 32'hDEAD_BEEF);
      rd_chk("R7", 5, 2, 32'h0);
      wr(5, 3, 32'hCAFE_F00D);
      rd_chk("R7", 5, 3, 32'h0);
   endtask

   task automatic t_remap();
      dec_chk("R6", 32'h8123_4567, 1'b1, 0, 4'h5, 8'hAB, 64'h0000_0001_4123_4567);
      dec_chk("R8", 32'h8000_0000, 1'b1, 0, 4'h5, 8'hAB, 64'h0000_0001_4000_0000);
      dec_chk("R9", 32'h9000_0000, 1'b0, 0, 4'h0, 8'h00, 64'h0);
      wr(0, 2, 32'h8000_0000);
      wr(0, 3, 32'h0);
      dec_chk("R6", 32'h8123_4567, 1'b1, 0, 4'h5, 8'hAB, 64'h0000_0000_8123_4567);
   endtask

   task automatic t_size();
      wr(2, 0, 32'h0);
      wr(2, 1, 32'h9000_0000);
      wr(2, 0, mk_ctrl(1'b1, 4'h3, 8'h11, 16'h0000));
      dec_chk("R3", 32'h9000_FFFF, 1'b1, 2, 4'h3, 8'h11, 64'h0000_0000_9000_FFFF);
      dec_chk("R3", 32'h9001_0000, 1'b0, 0, 4'h0, 8'h00, 64'h0);
      wr(2, 0, mk_ctrl(1'b1, 4'h3, 8'h11, 16'h00FF));
      dec_chk("R3", 32'h90FF_FFFF, 1'b1, 2, 4'h3, 8'h11, 64'h0000_0000_90FF_FFFF);
      dec_chk("R3", 32'h9100_0000, 1'b0, 0, 4'h0, 8'h00, 64'h0);
   endtask

   task automatic t_enable();
      wr(2, 0, mk_ctrl(1'b0, 4'h3, 8'h11, 16'h00FF));
      dec_chk("R4", 32'h9000_0000, 1'b0, 0, 4'h0, 8'h00, 64'h0);
      wr(2, 1, 32'hA000_0000);
      dec_chk("R4", 32'hA000_0000, 1'b0, 0, 4'h0, 8'h00, 64'h0);
      wr(2, 0, mk_ctrl(1'b1, 4'h3, 8'h11, 16'h00FF));
      // R10: decode follows the write accepted at the previous edge
      dec_chk("R10", 32'hA012_0000, 1'b1, 2, 4'h3, 8'h11, 64'h0000_0000_A012_0000);
      dec_chk("R10", 32'h9000_0000, 1'b0, 0, 4'h0, 8'h00, 64'h0);
   endtask

   task automatic t_priority();
      wr(6, 1, 32'hF000_0000);
      wr(6, 0, mk_ctrl(1'b1, 4'h1, 8'h0F, 16'h00FF));
      wr(7, 1, 32'hF000_0000);
      wr(7, 0, mk_ctrl(1'b1, 4'h2, 8'h1E, 16'h00FF));
      wr(4, 1, 32'hF000_0000);
      wr(4, 0, mk_ctrl(1'b1, 4'h4, 8'h44, 16'h000F));
      dec_chk("R5", 32'hF00A_0000, 1'b1, 4, 4'h4, 8'h44, 64'h0000_0000_F00A_0000);
      dec_chk("R5", 32'hF012_3456, 1'b1, 6, 4'h1, 8'h0F, 64'h0000_0000_F012_3456);
      wr(6, 0, 32'h0);
      dec_chk("R5", 32'hF012_3456, 1'b1, 7, 4'h2, 8'h1E, 64'h0000_0000_F012_3456);
   endtask

   task automatic t_passthru();
      wr(3, 1, 32'hC000_0000);
      wr(3, 2, 32'h1234_0000);
      wr(3, 0, mk_ctrl(1'b1, 4'h7, 8'h77, 16'h00FF));
      dec_chk("R7", 32'hC0AB_CDEF, 1'b1, 3, 4'h7, 8'h77, 64'h0000_0000_C0AB_CDEF);
      rd_chk("R7", 3, 2, 32'h0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_regs();
      t_remap();
      t_size();
      t_enable();
      t_priority();
      t_passthru();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         nchk++;
         nerr++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end
endmodule